// File: doc/BRIEF.md
# Per-Pin Interrupt Sense and Event Unit

This unit watches 32 synchronous input pins and turns configured transitions or levels into latched events. Every pin owns a two-bit sense code; the codes for the lower sixteen pins sit in one control word and those for the upper sixteen in a second word. Within each word the fields are placed in reverse pin order, so the lowest-numbered pin of the group occupies the top two bits. An event word collects the detections and is cleared by writing ones. A mask word selects which events may raise the single interrupt output.

The unit also holds a direction word that drives per-pin output enables. The four highest-numbered pins are input-only: a request to make them outputs is dropped. Software reaches all words through a simple word-addressed write port with a combinational read port. A build-time parameter decides whether the rising and falling codes detect edges or levels.

Top module: `gsense_top`

## Requirements
- R1: Pin n (0..15) takes its sense code from word SENSE_LO (address 3) and pin n (16..31) from word SENSE_HI (address 4), in both cases from bits [s+1:s] with s = (15 - n mod 16) * 2.
- R2: With LEVEL_MODE=0, code 01 sets the pin's event on a 0-to-1 change of the pin and not on a 1-to-0 change.
- R3: With LEVEL_MODE=0, code 10 sets the pin's event on a 1-to-0 change and not on a 0-to-1 change.
- R4: Code 00 sets the pin's event on either change, in both modes.
- R5: Code 11 never sets the pin's event, whatever the pin does.
- R6: With LEVEL_MODE=1, code 01 sets the event in every cycle the pin is high and code 10 in every cycle it is low, so a clear while the level persists leaves the bit set.
- R7: The event for pin n is bit 31-n of word EVENT (address 2); it is set the clock edge after the pin change is sampled.
- R8: Writing EVENT clears exactly the bits written as 1; bits written as 0 are unchanged.
- R9: A clear in the same cycle as a new detection on that pin leaves the event bit set.
- R10: Output irq is high exactly when some bit is set in both EVENT and MASK (address 1).
- R11: Word DIR (address 0) bit 31-n drives pin_oe[n]; bits 3..0 (pins 28..31) always read 0 and those pins are never enabled as outputs.
- R12: After reset DIR, MASK and EVENT are 0, both sense words are all ones (no detection) and irq is low.
- R13: Writes to addresses 5..7 change no word and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the word at addr |
| addr | input | 3 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the word at addr (combinational) |
| pin_i | input | 32 | Pin levels, bit n is pin n, synchronous to clk |
| pin_oe | output | 32 | Output enables, bit n is pin n |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest situation to reach is a clear landing in the very cycle a fresh detection arrives, because the clear write and the pin change must be presented to the same clock edge. The bench drives both on the same falling edge, then repeats the clear with the pin quiet to show the bit does drop. Level mode's refusal to stay cleared is shown with a second instance built with LEVEL_MODE=1, clearing while the level is held and again after it is released.

// File: rtl/gsense_pkg.sv
// Package: shared codes and word addresses for the pin sense unit.
// Assumes a word-addressed register port three bits wide.
package gsense_pkg;
    localparam logic [1:0] SENSE_BOTH = 2'b00;
    localparam logic [1:0] SENSE_RISE = 2'b01;
    localparam logic [1:0] SENSE_FALL = 2'b10;
    localparam logic [1:0] SENSE_OFF  = 2'b11;

    localparam logic [2:0] ADDR_DIR   = 3'd0;
    localparam logic [2:0] ADDR_MASK  = 3'd1;
    localparam logic [2:0] ADDR_EVENT = 3'd2;
    localparam logic [2:0] ADDR_SLO   = 3'd3;
    localparam logic [2:0] ADDR_SHI   = 3'd4;
endpackage

// File: rtl/gsense_detect.sv
// Module: per-pin detector. Picks each pin's two-bit code from one of two
// packed control words (reversed field order) and reports a detection per
// pin, returned in event-bit order (pin n -> bit NPIN-1-n).
// Assumes pin_i is already synchronous to clk.
module gsense_detect
    import gsense_pkg::*;
#(
    parameter int NPIN       = 32,
    parameter bit LEVEL_MODE = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_i,
    input  logic [NPIN-1:0] sense_lo,
    input  logic [NPIN-1:0] sense_hi,
    output logic [NPIN-1:0] det
);
    localparam int HALF = NPIN / 2;

    logic [NPIN-1:0] prev_q;

    // Remember last cycle's pin levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= pin_i;
    end

    for (genvar n = 0; n < NPIN; n++) begin : g_pin
        localparam int SH = (HALF - 1 - (n % HALF)) * 2;
        logic [1:0] code;
        logic       rise, fall, hit;

        if (n < HALF) begin : g_lo
            assign code = sense_lo[SH+1:SH];
        end else begin : g_hi
            assign code = sense_hi[SH+1:SH];
        end

        assign rise = pin_i[n] & ~prev_q[n];
        assign fall = ~pin_i[n] & prev_q[n];

        // Decode the sense code into a detection for this pin.
        always_comb begin
            case (code)
                SENSE_BOTH: hit = rise | fall;
                SENSE_RISE: hit = LEVEL_MODE ? pin_i[n] : rise;
                SENSE_FALL: hit = LEVEL_MODE ? ~pin_i[n] : fall;
                default:    hit = 1'b0;
            endcase
        end

        assign det[NPIN-1-n] = hit;

        // A reserved code must never yield a detection.
        assert_off_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (sense_lo == '1 && sense_hi == '1) |-> !hit);
    end
endmodule

// File: rtl/gsense_event.sv
// Module: event word with write-one-to-clear, detection priority over
// clear, and the masked interrupt OR. Assumes det and clr share bit order.
module gsense_event #(
    parameter int NPIN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] det,
    input  logic [NPIN-1:0] clr,
    input  logic [NPIN-1:0] mask,
    output logic [NPIN-1:0] ev,
    output logic            irq
);
    logic [NPIN-1:0] ev_q;

    // Latch detections; clears drop bits unless a detection arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) ev_q <= '0;
        else        ev_q <= (ev_q & ~clr) | det;
    end

    assign ev  = ev_q;
    assign irq = |(ev_q & mask);

    assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr & ~det)) |=> ((ev_q & $past(clr & ~det)) == '0));

    assert_detect_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr & det)) |=> ((ev_q & $past(clr & det)) == $past(clr & det)));
endmodule

// File: rtl/gsense_top.sv
// Module: top of the pin sense unit. Holds the direction, mask and sense
// words, decodes the register port, and ties detector and event word.
// Assumes a single-cycle write strobe and a combinational read.
module gsense_top
    import gsense_pkg::*;
#(
    parameter int NPIN       = 32,
    parameter int RO_FIRST   = 28,
    parameter bit LEVEL_MODE = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [2:0]      addr,
    input  logic [NPIN-1:0] wdata,
    output logic [NPIN-1:0] rdata,
    input  logic [NPIN-1:0] pin_i,
    output logic [NPIN-1:0] pin_oe,
    output logic            irq
);
    // Register bits of input-only pins (pin n lives at bit NPIN-1-n).
    localparam logic [NPIN-1:0] RO_MASK = {NPIN{1'b1}} >> RO_FIRST;

    logic [NPIN-1:0] dir_q, mask_q, slo_q, shi_q;
    logic [NPIN-1:0] det, clr, ev;

    // Control words, written from the register port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            mask_q <= '0;
            slo_q  <= '1;
            shi_q  <= '1;
        end else if (wr_en) begin
            case (addr)
                ADDR_DIR:  dir_q  <= wdata & ~RO_MASK;
                ADDR_MASK: mask_q <= wdata;
                ADDR_SLO:  slo_q  <= wdata;
                ADDR_SHI:  shi_q  <= wdata;
                default:   ;
            endcase
        end
    end

    assign clr = (wr_en && addr == ADDR_EVENT) ? wdata : '0;

    // Read multiplexer.
    always_comb begin
        case (addr)
            ADDR_DIR:   rdata = dir_q;
            ADDR_MASK:  rdata = mask_q;
            ADDR_EVENT: rdata = ev;
            ADDR_SLO:   rdata = slo_q;
            ADDR_SHI:   rdata = shi_q;
            default:    rdata = '0;
        endcase
    end

    for (genvar n = 0; n < NPIN; n++) begin : g_oe
        assign pin_oe[n] = dir_q[NPIN-1-n];
    end

    gsense_detect #(.NPIN(NPIN), .LEVEL_MODE(LEVEL_MODE)) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_i    (pin_i),
        .sense_lo (slo_q),
        .sense_hi (shi_q),
        .det      (det)
    );

    gsense_event #(.NPIN(NPIN)) u_event (
        .clk   (clk),
        .rst_n (rst_n),
        .det   (det),
        .clr   (clr),
        .mask  (mask_q),
        .ev    (ev),
        .irq   (irq)
    );

    assert_input_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_DIR) |=> (pin_oe[NPIN-1:RO_FIRST] == '0));

    assert_mask_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_MASK && wdata == '0) |=> !irq);
endmodule

// File: tb/tb_gsense_top.sv
`timescale 1ns/1ps
module tb_gsense_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] pins = '0;
    logic [31:0] rdata, rdata_l, oe, oe_l;
    logic        irq, irq_l;
    int          tests = 0;
    int          fails = 0;
    logic [31:0] slo, shi;

    always #2 clk = ~clk;

    gsense_top #(.LEVEL_MODE(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pin_i(pins), .pin_oe(oe), .irq(irq));

    gsense_top #(.LEVEL_MODE(1'b1)) dut_lvl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata_l), .pin_i(pins), .pin_oe(oe_l), .irq(irq_l));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R1 placement rule, computed independently.
    function automatic logic [31:0] fset(input logic [31:0] w, input int n, input logic [1:0] c);
        int sh = (15 - (n % 16)) * 2;
        return (w & ~(32'h3 << sh)) | ({30'd0, c} << sh);
    endfunction

    function automatic logic [31:0] eb(input int n);
        return 32'h1 << (31 - n);
    endfunction

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d, output logic [31:0] dl);
        addr = a; #0.5; d = rdata; dl = rdata_l;
    endtask

    task automatic set_sense(input int n, input logic [1:0] c);
        if (n < 16) begin slo = fset(slo, n, c); wr(3'd3, slo); end
        else        begin shi = fset(shi, n, c); wr(3'd4, shi); end
    endtask

    task automatic t_reset();
        logic [31:0] d, dl;
        rd(3'd0, d, dl); chk("R12 dir", d, 32'h0);
        rd(3'd1, d, dl); chk("R12 mask", d, 32'h0);
        rd(3'd2, d, dl); chk("R12 event", d, 32'h0);
        rd(3'd3, d, dl); chk("R12 sense_lo", d, 32'hFFFF_FFFF);
        rd(3'd4, d, dl); chk("R12 sense_hi", d, 32'hFFFF_FFFF);
        chk("R12 irq", {31'd0, irq}, 32'h0);
        pins = 32'hFFFF_FFFF; tick(); pins = '0; tick();
        rd(3'd2, d, dl); chk("R5 off code after reset", d, 32'h0);
        chk("R5 off code level dut", dl, 32'h0);
    endtask

    task automatic t_rise();
        logic [31:0] d, dl;
        set_sense(3, 2'b01);
        pins[3] = 1'b1; tick();
        rd(3'd2, d, dl); chk("R2 R7 rise sets bit 28", d, eb(3));
        wr(3'd2, eb(3));
        pins[3] = 1'b0; tick();
        rd(3'd2, d, dl); chk("R2 fall ignored", d, 32'h0);
    endtask

    task automatic t_fall();
        logic [31:0] d, dl;
        set_sense(20, 2'b10);
        pins[20] = 1'b1; tick();
        rd(3'd2, d, dl); chk("R3 rise ignored", d, 32'h0);
        pins[20] = 1'b0; tick();
        rd(3'd2, d, dl); chk("R3 R1 fall sets bit 11", d, eb(20));
        wr(3'd2, 32'hFFFF_FFFF);
    endtask

    task automatic t_both();
        logic [31:0] d, dl;
        set_sense(15, 2'b00);
        pins[15] = 1'b1; tick();
        rd(3'd2, d, dl); chk("R4 rise", d, eb(15));
        wr(3'd2, eb(15));
        rd(3'd2, d, dl); chk("R8 cleared", d, 32'h0);
        pins[15] = 1'b0; tick();
        rd(3'd2, d, dl); chk("R4 fall", d, eb(15));
        wr(3'd2, 32'h0);
        rd(3'd2, d, dl); chk("R8 zero write keeps", d, eb(15));
        wr(3'd2, ~eb(15));
        rd(3'd2, d, dl); chk("R8 other ones keep", d, eb(15));
        wr(3'd2, eb(15));
    endtask

    task automatic t_reserved();
        logic [31:0] d, dl;
        set_sense(3, 2'b11);
        pins[3] = 1'b1; tick(); pins[3] = 1'b0; tick();
        rd(3'd2, d, dl); chk("R5 reserved code", d, 32'h0);
    endtask

    task automatic t_collide();
        logic [31:0] d, dl;
        wr_en = 1'b1; addr = 3'd2; wdata = eb(15); pins[15] = 1'b1;
        tick(); wr_en = 1'b0;
        rd(3'd2, d, dl); chk("R9 detect beats clear", d, eb(15));
        wr(3'd2, eb(15));
        rd(3'd2, d, dl); chk("R9 later clear works", d, 32'h0);
    endtask

    task automatic t_irq();
        pins[15] = 1'b0; tick();
        chk("R10 masked off", {31'd0, irq}, 32'h0);
        wr(3'd1, eb(15));
        chk("R10 masked on", {31'd0, irq}, 32'h1);
        wr(3'd1, ~eb(15));
        chk("R10 other mask", {31'd0, irq}, 32'h0);
        wr(3'd1, 32'h0);
        wr(3'd2, 32'hFFFF_FFFF);
    endtask

    task automatic t_dir();
        logic [31:0] d, dl;
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, d, dl); chk("R11 readback", d, 32'hFFFF_FFF0);
        chk("R11 oe input-only", oe, 32'h0FFF_FFFF);
        wr(3'd0, 32'h8000_0001);
        chk("R11 oe pin0 only", oe, 32'h0000_0001);
    endtask

    task automatic t_badaddr();
        logic [31:0] d, dl;
        for (int a = 5; a < 8; a++) begin
            wr(3'(a), 32'h0);
            rd(3'(a), d, dl); chk("R13 unused reads 0", d, 32'h0);
        end
        rd(3'd0, d, dl); chk("R13 dir intact", d, 32'h8000_0000);
        rd(3'd3, d, dl); chk("R13 sense_lo intact", d, slo);
    endtask

    task automatic t_level();
        logic [31:0] d, dl;
        slo = 32'hFFFF_FFFF; shi = 32'hFFFF_FFFF;
        wr(3'd3, slo); wr(3'd4, shi);
        pins = '0; tick();
        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd2, d, dl); chk("R6 level start clear", dl, 32'h0);
        slo = fset(fset(slo, 5, 2'b01), 6, 2'b10);
        wr(3'd3, slo); tick();
        rd(3'd2, d, dl); chk("R6 low level", dl, eb(6));
        pins[5] = 1'b1; tick();
        rd(3'd2, d, dl); chk("R6 high level", dl, eb(5) | eb(6));
        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd2, d, dl); chk("R6 clear while held", dl, eb(5) | eb(6));
        pins[5] = 1'b0; pins[6] = 1'b1; tick();
        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd2, d, dl); chk("R6 clear after release", dl, 32'h0);
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        slo = 32'hFFFF_FFFF; shi = 32'hFFFF_FFFF;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rise();
        t_fall();
        t_both();
        t_reserved();
        t_collide();
        t_irq();
        t_dir();
        t_badaddr();
        t_level();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule